// File: doc/BRIEF.md
# Complex Mixing Oscillator

This block shifts the spectrum of a real sample stream by a programmable frequency. A phase accumulator advances by a signed 32-bit tuning word for every accepted input sample. The top bits of the phase address a quarter-wave amplitude table, which yields a cosine and a sine. Each real input sample is multiplied by both, giving an in-phase and a quadrature output. The output spectrum is the input spectrum moved by the tuning frequency.

The tuning word is written through a small register port into a holding register. It reaches the running accumulator only on a restart event, which is either a restart write or a rising edge on the synchronisation input. That event also returns the phase to zero, so several mixers that see the same event stay phase aligned. A control bit selects the conjugate exponential, which flips the sign of the quadrature path.

Top module: `ncoMixer`

## Requirements
- R1: After reset, outValid is 0 and outI and outQ are 0. The active tuning word, the phase and the invert control are all zero, so samples accepted right after reset give outQ = 0 and use cosine amplitude 32767.
- R2: outValid is high in exactly the third clock cycle after a cycle in which inValid is high, and low otherwise. Every accepted sample produces exactly one output, in order.
- R3: While outValid is low, outI and outQ hold their previous values.
- R4: A write with wrAddr = 0 stores wrData in the holding register and does not change the running oscillator. A write with wrAddr = 1 sets the invert control from wrData bit 0; wrData bit 1 = 1 requests a restart, and that bit is not stored.
- R5: A restart event copies the holding register into the active tuning word and sets the phase to 0. The first sample accepted after the event uses phase 0. A sample accepted in the event cycle itself still uses the old phase.
- R6: A rising edge of syncIn (low at the previous clock edge, high at this one) is a restart event. Holding syncIn high triggers no further events.
- R7: The phase advances by the active word, modulo 2^32, once for each accepted sample and never in a cycle without inValid. Words at or above 2^31 act as negative frequencies: for example, 3634203097 runs the phase backward by 660764199 per sample, which is -10 MHz at 65 MSPS.
- R8: The table index is phase bits [31:22]. Index bits [9:8] select the quadrant q and bits [7:0] give the offset a. With T(k) = floor(32767·16·u / (5·262144 − 4·u)), where u = k·(512 − k), the amplitudes are: q0 cos=T(256−a), sin=T(a); q1 cos=−T(a), sin=T(256−a); q2 cos=−T(256−a), sin=−T(a); q3 cos=T(a), sin=−T(256−a).
- R9: For a 14-bit signed sample x: outI = (x·cos + 4096) >>> 13 and outQ = (x·sin + 4096) >>> 13. Both are 16-bit signed results, and >>> is an arithmetic shift.
- R10: When the invert control is 1, the quadrature path uses −sin in place of sin. The in-phase path is unchanged.
- R11: A valid outI or outQ never equals −32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 1 | 0: tuning word holding register, 1: control |
| wrData | input | 32 | Write data |
| syncIn | input | 1 | External restart, acts on its rising edge |
| inValid | input | 1 | Input sample valid |
| inSample | input | 14 | Real input sample, two's complement |
| outValid | output | 1 | Output pair valid |
| outI | output | 16 | In-phase result, two's complement |
| outQ | output | 16 | Quadrature result, two's complement |

## Verification
The bench uses the default parameters: a 32-bit word, a 10-bit table index and 14-bit samples. The table then has only 257 quarter-wave entries, so a tuning word of 2^22 steps exactly one index per sample. About a thousand samples therefore reach every table entry in all four quadrants. This sweep is repeated with the conjugate selected and with the negative word, which walks the quadrants in the opposite direction. The sample pattern forces both full-scale extremes at regular points, so the rounding bound is tested at the largest products. Irregular gaps in inValid check that the phase advances only on accepted samples.

// File: rtl/ncoMixerPkg.sv
package ncoMixerPkg;

  // register port decode (the bench depends on these values)
  localparam int REG_FREQ          = 0;
  localparam int REG_CTRL          = 1;
  localparam int CTRL_INV_BIT      = 0;
  localparam int CTRL_RESTART_BIT  = 1;

  // strobes from control to datapath
  typedef struct packed {
    logic restart;
    logic invert;
  } mixCtrl_t;

endpackage

// File: rtl/ncoQuarterLut.sv
module ncoQuarterLut #(
  parameter int PHASE_W = 10,
  parameter int AMP_W   = 16
) (
  input  logic [PHASE_W-1:0]       phaseIdx,
  output logic signed [AMP_W-1:0]  cosOut,
  output logic signed [AMP_W-1:0]  sinOut
);
  localparam int OFF_W = PHASE_W - 2;
  localparam int QN    = 1 << OFF_W;
  localparam int IDX_W = OFF_W + 1;

  // rational sine approximation over one quarter, evaluated at elaboration
  function automatic logic [AMP_W-1:0] tabEntry(input int k);
    longint u, m, fs;
    u  = longint'(k) * longint'(2 * QN - k);
    m  = 4 * longint'(QN) * longint'(QN);
    fs = (longint'(1) << (AMP_W - 1)) - 1;
    return AMP_W'((fs * 16 * u) / (5 * m - 4 * u));
  endfunction

  logic signed [AMP_W-1:0] quarterTab [0:QN];

  for (genvar k = 0; k <= QN; k++) begin : g_tab
    assign quarterTab[k] = tabEntry(k);
  end

  logic [1:0]              quad;
  logic [OFF_W-1:0]        off;
  logic [IDX_W-1:0]        fwdIdx, revIdx;
  logic signed [AMP_W-1:0] fwd, rev;

  assign quad   = phaseIdx[PHASE_W-1 -: 2];
  assign off    = phaseIdx[OFF_W-1:0];
  assign fwdIdx = {1'b0, off};
  assign revIdx = IDX_W'(QN) - fwdIdx;
  assign fwd    = quarterTab[fwdIdx];
  assign rev    = quarterTab[revIdx];

  always_comb begin
    case (quad)
      2'd0:    begin cosOut = rev;  sinOut = fwd;  end
      2'd1:    begin cosOut = -fwd; sinOut = rev;  end
      2'd2:    begin cosOut = -rev; sinOut = -fwd; end
      default: begin cosOut = fwd;  sinOut = -rev; end
    endcase
  end
endmodule

// File: rtl/ncoMixerCtrl.sv
module ncoMixerCtrl
  import ncoMixerPkg::*;
#(
  parameter int FREQ_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic              wrAddr,
  input  logic [FREQ_W-1:0] wrData,
  input  logic              syncIn,
  output mixCtrl_t          ctl,
  output logic [FREQ_W-1:0] shadowWord
);
  logic invReg, syncPrev, freqWr, ctrlWr;

  assign freqWr = wrEn && (wrAddr == 1'(REG_FREQ));
  assign ctrlWr = wrEn && (wrAddr == 1'(REG_CTRL));

  always_ff @(posedge clk) begin
    if (rst) begin
      shadowWord <= '0;
      invReg     <= 1'b0;
      syncPrev   <= 1'b0;
    end else begin
      syncPrev <= syncIn;
      if (freqWr) shadowWord <= wrData;
      if (ctrlWr) invReg     <= wrData[CTRL_INV_BIT];
    end
  end

  // restart is a one-cycle strobe: write-1 request or sync rising edge
  assign ctl.restart = (ctrlWr && wrData[CTRL_RESTART_BIT]) || (syncIn && !syncPrev);
  assign ctl.invert  = invReg;
endmodule

// File: rtl/ncoMixerDatapath.sv
module ncoMixerDatapath
  import ncoMixerPkg::*;
#(
  parameter int FREQ_W  = 32,
  parameter int SAMP_W  = 14,
  parameter int AMP_W   = 16,
  parameter int PHASE_W = 10,
  parameter int OUT_W   = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  mixCtrl_t                 ctl,
  input  logic [FREQ_W-1:0]        shadowWord,
  input  logic                     inValid,
  input  logic signed [SAMP_W-1:0] inSample,
  output logic                     outValid,
  output logic signed [OUT_W-1:0]  outI,
  output logic signed [OUT_W-1:0]  outQ
);
  localparam int PROD_W = SAMP_W + AMP_W;
  localparam int SHIFT  = PROD_W - 1 - OUT_W;
  localparam logic signed [PROD_W-1:0] ROUND_ADD = PROD_W'(1) << (SHIFT - 1);

  function automatic logic signed [OUT_W-1:0] roundProd(input logic signed [PROD_W-1:0] p);
    return OUT_W'((p + ROUND_ADD) >>> SHIFT);
  endfunction

  logic [FREQ_W-1:0] acc, stepWord;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc      <= '0;
      stepWord <= '0;
    end else if (ctl.restart) begin
      stepWord <= shadowWord;
      acc      <= '0;
    end else if (inValid) begin
      acc <= acc + stepWord;
    end
  end

  // stage 1: capture sample with its phase index
  logic                     s1Valid;
  logic signed [SAMP_W-1:0] s1Samp;
  logic [PHASE_W-1:0]       s1Phase;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1Valid <= 1'b0;
      s1Samp  <= '0;
      s1Phase <= '0;
    end else begin
      s1Valid <= inValid;
      if (inValid) begin
        s1Samp  <= inSample;
        s1Phase <= acc[FREQ_W-1 -: PHASE_W];
      end
    end
  end

  logic signed [AMP_W-1:0] lutCos, lutSin;

  ncoQuarterLut #(.PHASE_W(PHASE_W), .AMP_W(AMP_W)) u_lut (
    .phaseIdx (s1Phase),
    .cosOut   (lutCos),
    .sinOut   (lutSin)
  );

  // stage 2: register amplitudes, apply conjugate selection
  logic                     s2Valid;
  logic signed [SAMP_W-1:0] s2Samp;
  logic signed [AMP_W-1:0]  s2Cos, s2Sin;

  always_ff @(posedge clk) begin
    if (rst) begin
      s2Valid <= 1'b0;
      s2Samp  <= '0;
      s2Cos   <= '0;
      s2Sin   <= '0;
    end else begin
      s2Valid <= s1Valid;
      if (s1Valid) begin
        s2Samp <= s1Samp;
        s2Cos  <= lutCos;
        s2Sin  <= ctl.invert ? -lutSin : lutSin;
      end
    end
  end

  // stage 3: multiply and round
  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      outI     <= '0;
      outQ     <= '0;
    end else begin
      outValid <= s2Valid;
      if (s2Valid) begin
        outI <= roundProd(PROD_W'(s2Samp) * PROD_W'(s2Cos));
        outQ <= roundProd(PROD_W'(s2Samp) * PROD_W'(s2Sin));
      end
    end
  end
endmodule

// File: rtl/ncoMixer.sv
module ncoMixer
  import ncoMixerPkg::*;
#(
  parameter int FREQ_W  = 32,
  parameter int SAMP_W  = 14,
  parameter int AMP_W   = 16,
  parameter int PHASE_W = 10,
  parameter int OUT_W   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic              wrAddr,
  input  logic [FREQ_W-1:0] wrData,
  input  logic              syncIn,
  input  logic              inValid,
  input  logic [SAMP_W-1:0] inSample,
  output logic              outValid,
  output logic [OUT_W-1:0]  outI,
  output logic [OUT_W-1:0]  outQ
);
  mixCtrl_t          ctl;
  logic [FREQ_W-1:0] shadowWord;

  ncoMixerCtrl #(.FREQ_W(FREQ_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .wrEn       (wrEn),
    .wrAddr     (wrAddr),
    .wrData     (wrData),
    .syncIn     (syncIn),
    .ctl        (ctl),
    .shadowWord (shadowWord)
  );

  ncoMixerDatapath #(
    .FREQ_W(FREQ_W), .SAMP_W(SAMP_W), .AMP_W(AMP_W), .PHASE_W(PHASE_W), .OUT_W(OUT_W)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .ctl        (ctl),
    .shadowWord (shadowWord),
    .inValid    (inValid),
    .inSample   (inSample),
    .outValid   (outValid),
    .outI       (outI),
    .outQ       (outQ)
  );
endmodule

// File: rtl/ncoMixerChecker.sv
module ncoMixerChecker #(
  parameter int FREQ_W = 32,
  parameter int OUT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic              outValid,
  input logic [OUT_W-1:0]  outI,
  input logic [OUT_W-1:0]  outQ,
  input logic              syncIn,
  input logic              wrEn,
  input logic              wrAddr,
  input logic [FREQ_W-1:0] wrData,
  input logic              ctlRestart
);
  localparam logic [OUT_W-1:0] MIN_CODE = {1'b1, {(OUT_W-1){1'b0}}};

  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (rst)              warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  p_valid_latency_r2: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3) |-> (outValid == $past(inValid, 3)));

  p_hold_idle_r3: assert property (@(posedge clk) disable iff (rst)
    (warm != 2'd0 && !outValid) |-> ($stable(outI) && $stable(outQ)));

  p_sync_single_r6: assert property (@(posedge clk) disable iff (rst)
    (warm != 2'd0 && syncIn && $past(syncIn) && !(wrEn && wrAddr && wrData[1])) |-> !ctlRestart);

  p_no_min_code_r11: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (outI != MIN_CODE && outQ != MIN_CODE));
endmodule

bind ncoMixer ncoMixerChecker #(.FREQ_W(FREQ_W), .OUT_W(OUT_W)) u_ncoMixerChecker (
  .clk        (clk),
  .rst        (rst),
  .inValid    (inValid),
  .outValid   (outValid),
  .outI       (outI),
  .outQ       (outQ),
  .syncIn     (syncIn),
  .wrEn       (wrEn),
  .wrAddr     (wrAddr),
  .wrData     (wrData),
  .ctlRestart (ctl.restart)
);

// File: tb/test_ncoMixer.sv
module test_ncoMixer;
  logic        clk = 1'b0;
  logic        rst;
  logic        wrEn, wrAddr, syncIn, inValid;
  logic [31:0] wrData;
  logic [13:0] inSample;
  logic        outValid;
  logic [15:0] outI, outQ;

  always #10 clk = ~clk;

  ncoMixer i_ncoMixer (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .syncIn(syncIn), .inValid(inValid), .inSample(inSample),
    .outValid(outValid), .outI(outI), .outQ(outQ)
  );

  int vectors = 0;
  int fails   = 0;

  // bench model of the oscillator state
  logic [31:0] mAcc = '0, mStep = '0, mShadow = '0;
  bit          mInv = 0, mSyncPrev = 0;
  string       curTag = "R1";

  int    expI [0:2047];
  int    expQ [0:2047];
  string expReq [0:2047];
  int    wrPtr = 0, rdPtr = 0;

  function automatic int tabVal(int k);
    longint u = longint'(k) * longint'(512 - k);
    return int'((longint'(32767) * 16 * u) / (longint'(5) * 262144 - 4 * u));
  endfunction

  function automatic int roundMul(int x, int a);
    longint p = longint'(x) * longint'(a);
    return int'((p + 4096) >>> 13);
  endfunction

  function automatic int pat(int n);
    if (n % 64 == 0) return -8192;
    if (n % 64 == 1) return 8191;
    return ((n * 1237 + 91) % 16384) - 8192;
  endfunction

  task automatic pushExp(int x);
    int a, c, s;
    logic [9:0] idx;
    idx = mAcc[31:22];
    a   = int'(idx[7:0]);
    case (idx[9:8])  // R8 quadrant mapping
      2'd0: begin c =  tabVal(256 - a); s =  tabVal(a);       end
      2'd1: begin c = -tabVal(a);       s =  tabVal(256 - a); end
      2'd2: begin c = -tabVal(256 - a); s = -tabVal(a);       end
      default: begin c = tabVal(a);     s = -tabVal(256 - a); end
    endcase
    if (mInv) s = -s;  // R10
    expI[wrPtr % 2048]   = roundMul(x, c);  // R9
    expQ[wrPtr % 2048]   = roundMul(x, s);
    expReq[wrPtr % 2048] = curTag;
    wrPtr++;
    mAcc = mAcc + mStep;  // R7
  endtask

  task automatic cyc(bit v, int x, bit we, bit a, logic [31:0] d, bit sy);
    @(negedge clk);
    inValid = v; inSample = 14'(x); wrEn = we; wrAddr = a; wrData = d; syncIn = sy;
    if (v) pushExp(x);  // sample in event cycle keeps old phase (R5)
    if (we) begin
      if (!a) mShadow = d;  // R4
      else begin
        mInv = d[0];
        if (d[1]) begin mStep = mShadow; mAcc = '0; end  // R5
      end
    end
    if (sy && !mSyncPrev) begin mStep = mShadow; mAcc = '0; end  // R6
    mSyncPrev = sy;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, '0, syncIn);
  endtask

  task automatic fail(string req, string what, int act, int exp);
    fails++;
    $display("FAIL %s: %s actual %0d expected %0d", req, what, act, exp);
  endtask

  // monitor, samples 2 time units after each rising edge
  bit p1 = 0, p2 = 0;
  logic [15:0] lastI = '0, lastQ = '0;
  always @(posedge clk) begin
    #2;
    if (rst) begin
      p1 = 0; p2 = 0; lastI = '0; lastQ = '0;
    end else begin
      vectors++;
      if (outValid !== p2) fail("R2", "outValid latency", int'(outValid), int'(p2));
      if (outValid) begin
        if (rdPtr == wrPtr) fail("R2", "unexpected output", rdPtr, wrPtr);
        else begin
          vectors++;
          if (int'($signed(outI)) != expI[rdPtr % 2048])
            fail(expReq[rdPtr % 2048], "outI", int'($signed(outI)), expI[rdPtr % 2048]);
          if (int'($signed(outQ)) != expQ[rdPtr % 2048])
            fail(expReq[rdPtr % 2048], "outQ", int'($signed(outQ)), expQ[rdPtr % 2048]);
          if (outI == 16'h8000 || outQ == 16'h8000)
            fail("R11", "minimum code on output", -32768, -32767);
          rdPtr++;
        end
      end else begin
        vectors++;
        if (outI !== lastI) fail("R3", "outI changed while idle", int'($signed(outI)), int'($signed(lastI)));
        if (outQ !== lastQ) fail("R3", "outQ changed while idle", int'($signed(outQ)), int'($signed(lastQ)));
      end
      lastI = outI; lastQ = outQ;
      p2 = p1; p1 = inValid;
    end
  end

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fail("R2", "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    rst = 1; wrEn = 0; wrAddr = 0; wrData = '0; syncIn = 0; inValid = 0; inSample = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state
    vectors++;
    if (outValid !== 1'b0) fail("R1", "outValid after reset", int'(outValid), 0);
    vectors++;
    if (outI !== 16'h0 || outQ !== 16'h0) fail("R1", "outputs after reset", int'($signed(outI)), 0);

    curTag = "R1";  // zero word: phase stays at 0
    for (int n = 0; n < 8; n++) cyc(1, pat(n), 0, 0, '0, 0);
    idle(4);

    // R8: one table index per sample, irregular gaps (R7)
    cyc(0, 0, 1, 0, 32'h0040_0000, 0);
    cyc(0, 0, 1, 1, 32'h2, 0);
    for (int n = 0; n < 1300; n++) begin
      curTag = (n < 4) ? "R5" : "R8";
      cyc((n % 5) != 4, pat(n), 0, 0, '0, 0);
    end
    idle(4);

    // R10: conjugate selected, no restart
    cyc(0, 0, 1, 1, 32'h1, 0);
    curTag = "R10";
    for (int n = 0; n < 1100; n++) cyc((n % 7) != 3, pat(n + 5), 0, 0, '0, 0);
    idle(4);
    cyc(0, 0, 1, 1, 32'h0, 0);

    // R4: new word held back until a restart
    cyc(0, 0, 1, 0, 32'hFFC0_0000, 0);
    curTag = "R4";
    for (int n = 0; n < 60; n++) cyc(1, pat(n + 11), 0, 0, '0, 0);
    idle(3);

    // R6: sync rising edge restarts; held high it does not retrigger
    cyc(0, 0, 0, 0, '0, 1);
    for (int n = 0; n < 1100; n++) begin
      curTag = (n < 4) ? "R6" : "R7";
      cyc((n % 6) != 2, pat(n + 17), 0, 0, '0, 1);
    end
    cyc(0, 0, 0, 0, '0, 0);
    cyc(0, 0, 0, 0, '0, 1);
    curTag = "R6";
    for (int n = 0; n < 20; n++) cyc(1, pat(n + 3), 0, 0, '0, 1);
    cyc(0, 0, 0, 0, '0, 0);

    // R7: +10 MHz and -10 MHz words at 65 MSPS
    cyc(0, 0, 1, 0, 32'd660764199, 0);
    cyc(0, 0, 1, 1, 32'h2, 0);
    curTag = "R7";
    for (int n = 0; n < 300; n++) cyc(1, pat(n + 29), 0, 0, '0, 0);
    cyc(0, 0, 1, 0, 32'd3634203097, 0);
    cyc(0, 0, 1, 1, 32'h2, 0);
    for (int n = 0; n < 300; n++) cyc((n % 4) != 1, pat(n + 41), 0, 0, '0, 0);
    idle(6);

    vectors++;
    if (rdPtr != wrPtr) fail("R2", "outputs delivered", rdPtr, wrPtr);
    finishRun();
  end
endmodule